// File: doc/BRIEF.md
# UART Receive Status and Error Tagging

This block is the receive-side status logic of one 16550-style UART channel. The receive shift register hands over each assembled character as a single-cycle pulse, together with a parity-check failure flag and a missing-stop-bit flag. The block stores each character in a 16-entry receive FIFO. The two error tags are stored in the same entry as the character, so an error is reported only when its own character reaches the read position.

The host sees the head character on the holding-register output and a 4-bit line status word. Bit 0 is data ready, bit 1 is overrun, bit 2 is parity error and bit 3 is framing error. Overrun is the exception to per-character reporting: it is flagged as soon as a character completes while the FIFO is full, and that character is thrown away. A receive-line-status interrupt is raised from these conditions when its enable input is set. Reading the status word acknowledges the conditions it reports.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status word is 0000 and the interrupt is low. Status bit 0 (data ready) is 1 exactly while at least one character is stored.
- R2: Characters are returned in arrival order. The holding-register output shows the head character, and a holding-register read removes it; the FIFO holds 16 characters.
- R3: A character that completes while 16 are stored, with no holding-register read in the same cycle, sets status bit 1 (overrun). That character is discarded and the 16 stored characters stay intact.
- R4: Status bit 2 (parity error) equals the parity tag of the character at the read position. Tags of characters behind it have no effect.
- R5: Status bit 3 (framing error) equals the framing tag of the character at the read position.
- R6: A status read clears the overrun bit. It also clears bits 2 and 3 for the current head character, until that character is popped; the next head then shows its own tags.
- R7: The interrupt is the line-status enable ANDed with the OR of status bits 1, 2 and 3. Overrun raises it at once, while a parity or framing error raises it only once the tagged character is at the head.
- R8: A host write to the status register changes neither the status word nor the interrupt.
- R9: A holding-register read with the FIFO empty does not pop. The holding-register output keeps the last value read, and later characters are received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Shift register has completed a character (one-cycle pulse) |
| char_data | input | 8 | Completed character |
| char_perr | input | 1 | Parity check failed for this character |
| char_ferr | input | 1 | Stop bit missing for this character |
| host_rd_data | input | 1 | Host reads the holding register (pops head) |
| host_rd_status | input | 1 | Host reads the line status word |
| host_wr_status | input | 1 | Host write strobe to the status register (ignored) |
| host_wr_data | input | 8 | Host write data (ignored) |
| lsi_en | input | 1 | Receive-line-status interrupt enable |
| rhr_data | output | 8 | Holding-register read data |
| line_status | output | 4 | {framing, parity, overrun, data ready} |
| lsi_irq | output | 1 | Receive-line-status interrupt |

## Verification
The sequence test sends three clean bytes. It shows whether the pointers keep arrival order and whether data ready follows the fill level. The tagging test queues a clean byte, then a parity-tagged byte, then a framing-tagged byte. This separates head-of-queue reporting from reporting the latest arrival, and it shows whether a status read acknowledges only the current head. The fill-to-seventeen test shows whether an overrun is flagged at once and whether the extra byte stays out of the stored sixteen. Tagged bytes sent with the enable low, a status write, and an empty-FIFO read test the interrupt gate, the ignored write, and the no-pop rule.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int ST_READY   = 0;
   localparam int ST_OVERRUN = 1;
   localparam int ST_PARITY  = 2;
   localparam int ST_FRAMING = 3;
   localparam int ST_W       = 4;

   typedef logic [ST_W-1:0] line_status_t;
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
   parameter int DEPTH   = 16,
   parameter int ENTRY_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               pop,
   input  logic [ENTRY_W-1:0] din,
   output logic [ENTRY_W-1:0] head,
   output logic               empty,
   output logic               full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   initial begin
      if (DEPTH < 2 || (1 << AW) != DEPTH)
         $error("rx_tag_fifo: DEPTH must be a power of two, at least 2");
      if (ENTRY_W < 3)
         $error("rx_tag_fifo: ENTRY_W too small for data plus two tags");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [AW-1:0]      wr_ptr, rd_ptr;
   logic [CW-1:0]      count;
   logic               do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full); // R3
   AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty); // R9
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
   import uart_rx_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         fifo_full,
   input  logic         fifo_empty,
   input  logic         head_perr,
   input  logic         head_ferr,
   input  logic         rd_status,
   input  logic         lsi_en,
   output line_status_t status,
   output logic         irq
);
   logic ovr_q, ack_q, ovr_event, pop_ok, err_any;

   assign ovr_event = push && fifo_full && !pop;
   assign pop_ok    = pop && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         if (ovr_event)      ovr_q <= 1'b1;
         else if (rd_status) ovr_q <= 1'b0;
         if (pop_ok)         ack_q <= 1'b0;
         else if (rd_status && !fifo_empty) ack_q <= 1'b1;
      end
   end

   always_comb begin
      status             = '0;
      status[ST_READY]   = !fifo_empty;
      status[ST_OVERRUN] = ovr_q;
      status[ST_PARITY]  = !fifo_empty && head_perr && !ack_q;
      status[ST_FRAMING] = !fifo_empty && head_ferr && !ack_q;
   end

   assign err_any = lsi_en &&
      (status[ST_OVERRUN] || status[ST_PARITY] || status[ST_FRAMING]);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= err_any;
         end
      end else begin : g_irq_comb
         assign irq = err_any;
         AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !lsi_en |-> !irq); // R7
      end
   endgenerate

   AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_event |=> status[ST_OVERRUN]); // R3
   AST_RD_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !ovr_event) |=> !status[ST_OVERRUN]); // R6
   AST_EMPTY_NO_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !(status[ST_PARITY] || status[ST_FRAMING])); // R4
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_valid,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_perr,
   input  logic              char_ferr,
   input  logic              host_rd_data,
   input  logic              host_rd_status,
   input  logic              host_wr_status,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              lsi_en,
   output logic [DATA_W-1:0] rhr_data,
   output logic [ST_W-1:0]   line_status,
   output logic              lsi_irq
);
   localparam int ENTRY_W = DATA_W + 2;
   localparam int PE_BIT  = DATA_W;
   localparam int FE_BIT  = DATA_W + 1;

   initial begin
      if (DATA_W < 5 || DATA_W > 9)
         $error("uart_rx_status: DATA_W must be 5..9");
   end

   logic [ENTRY_W-1:0] head;
   logic               empty, full;
   logic [DATA_W-1:0]  last_q;
   line_status_t       status;
   logic               unused_wr;

   assign unused_wr = host_wr_status ^ (^host_wr_data);

   rx_tag_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (char_valid),
      .pop   (host_rd_data),
      .din   ({char_ferr, char_perr, char_data}),
      .head  (head),
      .empty (empty),
      .full  (full)
   );

   rx_line_status #(.IRQ_REG(IRQ_REG)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (char_valid),
      .pop        (host_rd_data),
      .fifo_full  (full),
      .fifo_empty (empty),
      .head_perr  (head[PE_BIT]),
      .head_ferr  (head[FE_BIT]),
      .rd_status  (host_rd_status),
      .lsi_en     (lsi_en),
      .status     (status),
      .irq        (lsi_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    last_q <= '0;
      else if (host_rd_data && !empty) last_q <= head[DATA_W-1:0];
   end

   assign rhr_data    = empty ? last_q : head[DATA_W-1:0];
   assign line_status = status;

   AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |=> line_status[ST_READY]); // R1
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && host_rd_data && !char_valid) |=> $stable(rhr_data)); // R9
endmodule

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_valid = 1'b0;
   logic [7:0] char_data = '0;
   logic       char_perr = 1'b0, char_ferr = 1'b0;
   logic       host_rd_data = 1'b0, host_rd_status = 1'b0;
   logic       host_wr_status = 1'b0;
   logic [7:0] host_wr_data = '0;
   logic       lsi_en = 1'b0;
   logic [7:0] rhr_data;
   logic [3:0] line_status;
   logic       lsi_irq;
   int         n_vec = 0, n_err = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   uart_rx_status dut_i (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr), .host_rd_data(host_rd_data),
      .host_rd_status(host_rd_status), .host_wr_status(host_wr_status),
      .host_wr_data(host_wr_data), .lsi_en(lsi_en), .rhr_data(rhr_data),
      .line_status(line_status), .lsi_irq(lsi_irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(logic [7:0] d, logic p, logic f);
      @(negedge clk);
      char_valid = 1'b1; char_data = d; char_perr = p; char_ferr = f;
      @(negedge clk);
      char_valid = 1'b0; char_perr = 1'b0; char_ferr = 1'b0;
   endtask

   task automatic pop_expect(string req, logic [7:0] exp);
      @(negedge clk);
      check(req, rhr_data, exp);
      host_rd_data = 1'b1;
      @(negedge clk);
      host_rd_data = 1'b0;
   endtask

   task automatic read_status();
      @(negedge clk);
      host_rd_status = 1'b1;
      @(negedge clk);
      host_rd_status = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset status", line_status, 4'b0000);
      check("R1 reset irq", lsi_irq, 1'b0);
   endtask

   task automatic t_order();
      push(8'hA1, 0, 0); push(8'hB2, 0, 0); push(8'hC3, 0, 0);
      check("R1 ready after push", line_status, 4'b0001);
      pop_expect("R2 order 0", 8'hA1);
      pop_expect("R2 order 1", 8'hB2);
      pop_expect("R2 order 2", 8'hC3);
      check("R1 ready clears when empty", line_status, 4'b0000);
   endtask

   task automatic t_tags();
      lsi_en = 1'b1;
      push(8'h41, 0, 0); push(8'h42, 1, 0); push(8'h43, 0, 1);
      check("R4 tag behind head ignored", line_status, 4'b0001);
      check("R7 no irq before tagged head", lsi_irq, 1'b0);
      pop_expect("R2 head clean", 8'h41);
      check("R4 parity at head", line_status, 4'b0101);
      check("R7 irq on parity head", lsi_irq, 1'b1);
      read_status();
      check("R6 status read clears parity", line_status, 4'b0001);
      check("R7 irq drops after read", lsi_irq, 1'b0);
      pop_expect("R2 head parity char", 8'h42);
      check("R5 framing at head", line_status, 4'b1001);
      check("R7 irq on framing head", lsi_irq, 1'b1);
      read_status();
      check("R6 status read clears framing", line_status, 4'b0001);
      pop_expect("R2 head framing char", 8'h43);
      check("R1 empty after tags", line_status, 4'b0000);
   endtask

   task automatic t_overrun();
      lsi_en = 1'b1;
      for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 0, 0);
      check("R3 full without overrun", line_status, 4'b0001);
      check("R7 no irq when full", lsi_irq, 1'b0);
      push(8'hEE, 0, 0);
      check("R3 overrun set", line_status, 4'b0011);
      check("R7 overrun irq at once", lsi_irq, 1'b1);
      read_status();
      check("R6 read clears overrun", line_status, 4'b0001);
      check("R7 irq drops after overrun read", lsi_irq, 1'b0);
      for (int i = 0; i < 16; i++) pop_expect("R3 stored data intact", 8'h10 + 8'(i));
      check("R3 overrun byte discarded", line_status, 4'b0000);
   endtask

   task automatic t_irq_off();
      lsi_en = 1'b0;
      push(8'h66, 0, 1);
      check("R5 framing with enable off", line_status, 4'b1001);
      check("R7 irq gated by enable", lsi_irq, 1'b0);
      pop_expect("R2 enable-off char", 8'h66);
   endtask

   task automatic t_write_ignored();
      lsi_en = 1'b1;
      push(8'h55, 1, 0);
      @(negedge clk);
      host_wr_status = 1'b1; host_wr_data = 8'h00;
      @(negedge clk);
      host_wr_status = 1'b0; host_wr_data = 8'hFF;
      check("R8 status write ignored", line_status, 4'b0101);
      check("R8 irq unchanged by write", lsi_irq, 1'b1);
      pop_expect("R8 data unchanged by write", 8'h55);
   endtask

   task automatic t_empty_read();
      @(negedge clk);
      host_rd_data = 1'b1;
      @(negedge clk);
      host_rd_data = 1'b0;
      check("R9 empty read keeps last", rhr_data, 8'h55);
      check("R9 empty read no ready", line_status, 4'b0000);
      push(8'h77, 0, 0);
      check("R9 ready after empty read", line_status, 4'b0001);
      pop_expect("R9 next char intact", 8'h77);
      check("R9 empty again", line_status, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_tags();
      t_overrun();
      t_irq_off();
      t_write_ignored();
      t_empty_read();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end
endmodule